// File: doc/BRIEF.md
# Host Interface Mode Auto-Detect Sequencer

This block runs once after every power-up, hard reset or soft reset request and decides whether the device's host port works as I2C or as SPI. It senses the shared address/serial-out pin while it waits through a detection window. The pin reading comes from an analog sensing circuit outside this block and arrives as a two-bit code: driven low, driven high, or left floating. A low or a high pin selects I2C. A floating pin selects SPI. The chosen mode is latched and stays in force until the next reset of either kind.

The decision is never taken before the detection window has elapsed. It also needs a run of consecutive identical pin readings, so a glitch near the end of the window delays the decision rather than corrupting it. After the decision the block signals that the sequence is complete on the interrupt line. If the line stood high when the sequence began, it dips low for a fixed number of cycles and returns high. If it stood low, it simply rises. The busy flag stays set, and the host interface must stay disabled, until that signalling is over.

A soft reset request at any time, including in the middle of a window or of the completion pulse, throws away the progress made so far and starts the sequence again.

Top module: `hostif_mode_detect`

## Requirements
- R1: The pin code maps to a mode as follows: 2'b00 (low) and 2'b01 (high) select I2C, shown as `mode_spi`=0. 2'b10 (floating) selects SPI, shown as `mode_spi`=1. The unused code 2'b11 is treated as floating.
- R2: A sequence starts on the first clock edge after `rst_n` is released, and again on every edge at which `soft_rst_req` is high. After a request edge, `busy` is 1 and `mode_spi` is 0, and the window count restarts from zero, even when a sequence is already running.
- R3: The mode decision is never taken before edge WIN_CYC-1 of the sequence, where edge 0 is the first edge of the sequence.
- R4: A decision needs the STABLE_N samples taken just before it to have the same class. If they do not, the decision waits for the first edge at which this holds. The class used is the class of those samples.
- R5: Once `busy` has fallen, `mode_spi` keeps its value whatever the pin does, until the next soft request or hard reset.
- R6: `busy` is 1 from reset or request until completion signalling ends. It falls on the edge at which `irq_level` returns or rises to 1. While `busy` is 0, `irq_level` is 1.
- R7: If `irq_level` was 1 when the sequence started, it goes to 0 on the decision edge and stays 0 for exactly PULSE_CYC cycles before returning to 1.
- R8: If `irq_level` was 0 when the sequence started (a soft request during a low pulse), it stays 0 through the sequence and rises on the decision edge with no further low phase.
- R9: While `rst_n` is low, `busy`=1, `mode_spi`=0 and `irq_level`=IRQ_RST_LVL (default 1) asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst_req | input | 1 | Synchronous soft reset request, restarts the sequence |
| pin_sense | input | 2 | Sensed pin state: 00 low, 01 high, 10 floating, 11 treated as floating |
| mode_spi | output | 1 | Latched mode: 0 I2C, 1 SPI |
| busy | output | 1 | Detection or completion signalling in progress |
| irq_level | output | 1 | Level driven on the interrupt pin |

## Verification
The bench builds the block with WIN_CYC=20, STABLE_N=4 and PULSE_CYC=5, instead of the millisecond-scale default window. With these values a whole sequence takes about 25 cycles, so every pin code and every placement of a glitch can be run from hard reset. Glitch placements include edges just before, at and after the last window edge. These short counts also let a soft request land inside the window and inside the low pulse, which is the only way to reach the low-prior completion case.

// File: rtl/hmd_pkg.sv
package hmd_pkg;

  typedef enum logic [1:0] {
    PIN_LOW   = 2'b00,
    PIN_HIGH  = 2'b01,
    PIN_FLOAT = 2'b10
  } pin_class_e;

  typedef enum logic [1:0] {
    SEQ_WINDOW = 2'b00,
    SEQ_EXTEND = 2'b01,
    SEQ_PULSE  = 2'b10,
    SEQ_IDLE   = 2'b11
  } seq_state_e;

  // Raw sense code to pin class; the unused code reads as floating.
  function automatic pin_class_e classify(input logic [1:0] code);
    pin_class_e c;
    case (code)
      2'b00:   c = PIN_LOW;
      2'b01:   c = PIN_HIGH;
      default: c = PIN_FLOAT;
    endcase
    return c;
  endfunction

  // Only a floating pin selects SPI; either driven level selects I2C.
  function automatic logic class_selects_spi(input pin_class_e c);
    return (c == PIN_FLOAT);
  endfunction

  // State after a decision: straight to idle when signalling is done at once.
  function automatic seq_state_e after_decision(input logic done_now);
    return done_now ? SEQ_IDLE : SEQ_PULSE;
  endfunction

endpackage

// File: rtl/hmd_pin_filter.sv
module hmd_pin_filter
  import hmd_pkg::*;
#(
  parameter int unsigned STABLE_N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [1:0] pin_code,
  output pin_class_e cls_q,
  output logic       stable
);
  localparam int unsigned CNT_W = $clog2(STABLE_N + 1);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(STABLE_N);

  pin_class_e       cls_now;
  logic [CNT_W-1:0] run_q;
  logic             same_w;

  assign cls_now = classify(pin_code);
  assign same_w  = (cls_now == cls_q) && (run_q != '0);
  assign stable  = (run_q >= RUN_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= PIN_LOW;
      run_q <= '0;
    end else if (clear) begin
      cls_q <= PIN_LOW;
      run_q <= '0;
    end else begin
      cls_q <= cls_now;
      if (same_w) begin
        if (run_q < RUN_FULL) run_q <= run_q + 1'b1;
      end else begin
        run_q <= CNT_W'(1);
      end
    end
  end

  // R4: run length never exceeds the required count
  a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_FULL);

  // R4: a class change restarts the run at one sample
  a_r4_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cls_now != cls_q) |=> (run_q == CNT_W'(1)));

endmodule

// File: rtl/hmd_window_timer.sv
module hmd_window_timer #(
  parameter int unsigned WIN_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic win_end
);
  localparam int unsigned W = $clog2(WIN_CYC + 1);
  localparam logic [W-1:0] LAST = W'(WIN_CYC - 1);

  logic [W-1:0] cnt_q;

  assign win_end = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (restart)                cnt_q <= '0;
    else if (run && cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  // R3: the window count stops at its last value
  a_r3_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2: a restart always returns the count to zero
  a_r2_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/hmd_done_pulse.sv
module hmd_done_pulse #(
  parameter int unsigned PULSE_CYC   = 12,
  parameter bit          IRQ_RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic fire,
  output logic irq_q,
  output logic done_evt
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_CYC - 1);

  logic          prior_hi_q;
  logic          active_q;
  logic [PW-1:0] pcnt_q;
  logic          pulse_end_w;
  logic          fire_direct_w;

  assign pulse_end_w   = active_q && (pcnt_q == P_LAST);
  assign fire_direct_w = fire && !prior_hi_q;
  assign done_evt      = !restart && (fire_direct_w || pulse_end_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= IRQ_RST_LVL;
      prior_hi_q <= IRQ_RST_LVL;
      active_q   <= 1'b0;
      pcnt_q     <= '0;
    end else if (restart) begin
      prior_hi_q <= irq_q;
      active_q   <= 1'b0;
      pcnt_q     <= '0;
    end else if (fire) begin
      if (prior_hi_q) begin
        irq_q    <= 1'b0;
        active_q <= 1'b1;
        pcnt_q   <= '0;
      end else begin
        irq_q    <= 1'b1;
      end
    end else if (active_q) begin
      if (pulse_end_w) begin
        irq_q    <= 1'b1;
        active_q <= 1'b0;
      end else begin
        pcnt_q   <= pcnt_q + 1'b1;
      end
    end
  end

  // R7: with a high prior level the decision pulls the line low
  a_r7_fall_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart && prior_hi_q) |=> !irq_q);

  // R8: with a low prior level the decision only raises the line
  a_r8_rise_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart && !prior_hi_q) |=> irq_q);

  // R7: the pulse counter stays inside the pulse length
  a_r7_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= P_LAST);

endmodule

// File: rtl/hostif_mode_detect.sv
module hostif_mode_detect
  import hmd_pkg::*;
#(
  parameter int unsigned WIN_CYC     = 50000,
  parameter int unsigned STABLE_N    = 8,
  parameter int unsigned PULSE_CYC   = 12,
  parameter bit          IRQ_RST_LVL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst_req,
  input  logic [1:0] pin_sense,
  output logic       mode_spi,
  output logic       busy,
  output logic       irq_level
);
  seq_state_e st_q;
  pin_class_e cls_w;
  logic       stable_w;
  logic       win_end_w;
  logic       window_run_w;
  logic       decide_w;
  logic       done_w;
  logic       irq_w;
  logic       mode_q;
  logic       busy_q;

  assign window_run_w = (st_q == SEQ_WINDOW);
  assign decide_w     = !soft_rst_req && stable_w &&
                        (win_end_w || st_q == SEQ_EXTEND);

  hmd_pin_filter #(.STABLE_N(STABLE_N)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (soft_rst_req),
    .pin_code (pin_sense),
    .cls_q    (cls_w),
    .stable   (stable_w)
  );

  hmd_window_timer #(.WIN_CYC(WIN_CYC)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (soft_rst_req),
    .run     (window_run_w),
    .win_end (win_end_w)
  );

  hmd_done_pulse #(.PULSE_CYC(PULSE_CYC), .IRQ_RST_LVL(IRQ_RST_LVL)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (soft_rst_req),
    .fire     (decide_w),
    .irq_q    (irq_w),
    .done_evt (done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_WINDOW;
      mode_q <= 1'b0;
      busy_q <= 1'b1;
    end else if (soft_rst_req) begin
      st_q   <= SEQ_WINDOW;
      mode_q <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      if (decide_w) mode_q <= class_selects_spi(cls_w);
      if (done_w)   busy_q <= 1'b0;
      case (st_q)
        SEQ_WINDOW: if (win_end_w) st_q <= decide_w ? after_decision(done_w) : SEQ_EXTEND;
        SEQ_EXTEND: if (decide_w)  st_q <= after_decision(done_w);
        SEQ_PULSE:  if (done_w)    st_q <= SEQ_IDLE;
        default:    st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mode_spi  = mode_q;
  assign busy      = busy_q;
  assign irq_level = irq_w;

  // R5: the latched mode does not move after completion
  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !soft_rst_req) |=> $stable(mode_q));

  // R6: the interrupt line is high whenever the sequence is over
  a_r6_idle_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> irq_w);

  // R6: busy only falls together with a rising interrupt line
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $rose(irq_w));

  // R2: a soft request re-enters detection with I2C shown
  a_r2_soft_restart: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> (busy_q && !mode_q));

  // R3: completion never comes while the window still runs
  a_r3_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (window_run_w && !win_end_w) |-> !done_w);

endmodule

// File: tb/test_hostif_mode_detect.sv
module test_hostif_mode_detect;
  localparam int unsigned WIN = 20;
  localparam int unsigned STB = 4;
  localparam int unsigned PUL = 5;
  localparam int unsigned NVEC = 10;

  // {pin a[31:30], pin b[29:28], glitch start[27:20], glitch len[19:12],
  //  expected mode[11:8], expected edges until busy low[7:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {2'b00, 2'b00, 8'd0,  8'd0,   4'd0, 8'd25},
    {2'b01, 2'b01, 8'd0,  8'd0,   4'd0, 8'd25},
    {2'b10, 2'b10, 8'd0,  8'd0,   4'd1, 8'd25},
    {2'b11, 2'b11, 8'd0,  8'd0,   4'd1, 8'd25},
    {2'b00, 2'b10, 8'd17, 8'd200, 4'd1, 8'd27},
    {2'b10, 2'b00, 8'd18, 8'd1,   4'd1, 8'd29},
    {2'b10, 2'b01, 8'd5,  8'd2,   4'd1, 8'd25},
    {2'b01, 2'b10, 8'd19, 8'd1,   4'd0, 8'd25},
    {2'b00, 2'b10, 8'd15, 8'd200, 4'd1, 8'd25},
    {2'b00, 2'b10, 8'd16, 8'd200, 4'd1, 8'd26}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst_req = 1'b0;
  logic [1:0] pin_sense = 2'b00;
  logic       mode_spi, busy, irq_level;
  int         n_checks = 0;
  int         n_errors = 0;

  always #10 clk = ~clk;

  hostif_mode_detect #(.WIN_CYC(WIN), .STABLE_N(STB), .PULSE_CYC(PUL), .IRQ_RST_LVL(1'b1))
  i_hostif_mode_detect (
    .clk(clk), .rst_n(rst_n), .soft_rst_req(soft_rst_req), .pin_sense(pin_sense),
    .mode_spi(mode_spi), .busy(busy), .irq_level(irq_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code_at(input int k, input logic [1:0] a, input logic [1:0] b,
                                         input int g, input int len);
    return (k >= g && k < g + len) ? b : a;
  endfunction

  // Drives the pin per edge, counts edges until busy is seen low and low irq samples while busy.
  task automatic measure(input logic [1:0] a, input logic [1:0] b, input int g, input int len,
                         output int edges, output int lows);
    edges = 0;
    lows  = 0;
    for (int k = 0; k < 1000; k++) begin
      pin_sense = code_at(k, a, b, g, len);
      @(posedge clk);
      #1;
      edges++;
      if (!busy) break;
      if (!irq_level) lows++;
    end
  endtask

  task automatic soft_req();
    soft_rst_req = 1'b1;
    @(posedge clk);
    #1;
    soft_rst_req = 1'b0;
  endtask

  task automatic hard_reset(input logic [1:0] first_pin);
    @(negedge clk);
    rst_n = 1'b0;
    pin_sense = first_pin;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int e, l;
    // R9: reset state
    #15;
    chk("R9 busy in reset", int'(busy), 1);
    chk("R9 mode in reset", int'(mode_spi), 0);
    chk("R9 irq in reset", int'(irq_level), 1);

    // R1 R3 R4 R7: table of pin patterns, each from hard reset
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] w;
      w = VECS[v];
      hard_reset(w[31:30]);
      measure(w[31:30], w[29:28], int'(w[27:20]), int'(w[19:12]), e, l);
      chk($sformatf("R3/R4 vec%0d edges", v), e, int'(w[7:0]));
      chk($sformatf("R1 vec%0d mode", v), int'(mode_spi), int'(w[11:8]));
      chk($sformatf("R7 vec%0d low pulse", v), l, PUL);
    end

    // R5: mode holds after completion while the pin wanders
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 40; k++) begin
        pin_sense = 2'(k % 3);
        @(posedge clk);
        #1;
        if (mode_spi != 1'b1 || busy != 1'b0) bad++;
      end
      chk("R5 mode held", bad, 0);
    end

    // R2: soft request restarts, shows I2C, pin low now selects I2C
    pin_sense = 2'b00;
    soft_req();
    chk("R2 busy after request", int'(busy), 1);
    chk("R2 mode cleared", int'(mode_spi), 0);
    measure(2'b00, 2'b00, 0, 0, e, l);
    chk("R2 edges after request", e, WIN + PUL);
    chk("R1 low pin mode", int'(mode_spi), 0);
    chk("R7 low pulse after request", l, PUL);

    // R2: request in the middle of the window restarts the count
    soft_req();
    for (int k = 0; k < 10; k++) begin
      pin_sense = 2'b10;
      @(posedge clk);
    end
    #1;
    soft_req();
    measure(2'b10, 2'b10, 0, 0, e, l);
    chk("R2 window restart edges", e, WIN + PUL);
    chk("R1 floating mode", int'(mode_spi), 1);

    // R8: request during the low pulse gives a rise-only completion
    soft_req();
    for (int k = 0; k < WIN + 1; k++) begin
      pin_sense = 2'b10;
      @(posedge clk);
    end
    #1;
    chk("R7 irq low inside pulse", int'(irq_level), 0);
    soft_req();
    chk("R8 irq held low at restart", int'(irq_level), 0);
    measure(2'b10, 2'b10, 0, 0, e, l);
    chk("R8 edges with low prior", e, WIN);
    chk("R8 irq low through sequence", l, WIN - 1);
    chk("R6 irq high at completion", int'(irq_level), 1);
    chk("R8 mode", int'(mode_spi), 1);

    // R9: hard reset inside a low pulse restores the reset levels
    soft_req();
    for (int k = 0; k < WIN + 1; k++) begin
      pin_sense = 2'b01;
      @(posedge clk);
    end
    #1;
    rst_n = 1'b0;
    #1;
    chk("R9 irq on hard reset", int'(irq_level), 1);
    chk("R9 busy on hard reset", int'(busy), 1);
    chk("R9 mode on hard reset", int'(mode_spi), 0);
    @(negedge clk);
    rst_n = 1'b1;
    measure(2'b01, 2'b01, 0, 0, e, l);
    chk("R6 edges after hard reset", e, WIN + PUL);
    chk("R7 pulse after hard reset", l, PUL);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule